// File: doc/BRIEF.md
# Command/Address Packet Parity Monitor

This block watches an 8-bit command/address bus on the receiving side. Each packet travels with one parity bit and a valid strobe. The block tests every valid packet for even parity on its own, including the second packet of a two-packet command. When a packet fails, it pulls an active-low alert output low for a programmed number of cycles.

On each failure it also counts the error and records the first failing byte together with its packet index. The alert, the count and the record return to idle when a clear pulse arrives or when reset is applied. A system controller watches the alert line and reads the count and the record to decide how to recover.

Top module: `ca_parity_monitor`

## Requirements
- R1: A packet passes when `pkt_data[7:0]` and `pkt_par` together hold an even number of ones. This means the correct parity bit is the XOR of the eight data bits. A passing packet never pulls `alert_n` low.
- R2: A valid packet that fails parity makes `alert_n` go low on the clock edge that samples it, so the low level shows in the cycle after the packet.
- R3: `alert_n` stays low for exactly `STRETCH` cycles (default 4) after the last failing packet. A further failure while it is low restarts that count.
- R4: A packet presented with `pkt_valid` low is never checked. It does not touch the alert, the counter or the capture record.
- R5: Each packet is checked on its own parity bit from the same cycle. Packet index 0 is the first packet of a command and index 1 is the second. Nothing carries over from one packet to the next, so a passing second packet after a failing first packet adds no error.
- R6: `err_count` goes up by one for each failing valid packet and stops at its all-ones value (255 by default).
- R7: The first failing packet after idle loads `cap_byte` with its data byte and `cap_idx` with its index, and sets `cap_valid`. Later failures leave the record unchanged until a clear.
- R8: A `clr` pulse brings the block back to idle on the next cycle: `alert_n` high, `err_count` zero, `cap_valid`, `cap_byte` and `cap_idx` zero. A clear takes priority over a failing packet in the same cycle.
- R9: When `rst_n` is low (active low), `alert_n` is high and the count and capture record are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_valid | input | 1 | Packet present this cycle |
| pkt_data | input | 8 | Command/address packet byte |
| pkt_par | input | 1 | Parity bit sent with the packet |
| pkt_idx | input | 1 | Packet position within its command (0 or 1) |
| clr | input | 1 | Return alert, count and record to idle |
| alert_n | output | 1 | Registered, stretched parity alert, active low |
| err_count | output | CNT_W | Saturating count of failing packets |
| cap_valid | output | 1 | A failing packet has been recorded |
| cap_byte | output | 8 | Data byte of the first failing packet |
| cap_idx | output | 1 | Packet index of the first failing packet |

## Verification
The stimulus sends a passing second packet right after a failing first packet. A design that carried parity across packets would count a second error or hold the alert for too long. A new failure arrives just before the alert would release. A design that does not restart the stretch would release the alert early, and one that stretched by the wrong count would release it a cycle early or late. A packet with bad parity is sent with its strobe low, which a design that ignores the strobe would flag. Other cases cover a clear that lands in the same cycle as a failure, a later failure that must not overwrite the record, and a long run of failures that must stop the counter at 255 instead of wrapping it to zero.

// File: rtl/ca_parity_monitor.sv
module ca_parity_monitor #(
  parameter int STRETCH = 4,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic [7:0]       pkt_data,
  input  logic             pkt_par,
  input  logic             pkt_idx,
  input  logic             clr,
  output logic             alert_n,
  output logic [CNT_W-1:0] err_count,
  output logic             cap_valid,
  output logic [7:0]       cap_byte,
  output logic             cap_idx
);

  localparam int              SW      = $clog2(STRETCH + 1);
  localparam logic [SW-1:0]   S_LOAD  = SW'(STRETCH);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic          odd, hit;
  logic [SW-1:0] hold_q, hold_d;

  assign odd = ^{pkt_data, pkt_par};
  assign hit = pkt_valid & odd & ~clr;

  always_comb begin
    if (clr)                hold_d = '0;
    else if (hit)           hold_d = S_LOAD;
    else if (hold_q != '0)  hold_d = hold_q - 1'b1;
    else                    hold_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      alert_n <= 1'b1;
    end else begin
      hold_q  <= hold_d;
      alert_n <= (hold_d == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          err_count <= '0;
    else if (clr)                        err_count <= '0;
    else if (hit && err_count != CNT_MAX) err_count <= err_count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      cap_byte  <= '0;
      cap_idx   <= 1'b0;
    end else if (clr) begin
      cap_valid <= 1'b0;
      cap_byte  <= '0;
      cap_idx   <= 1'b0;
    end else if (hit && !cap_valid) begin
      cap_valid <= 1'b1;
      cap_byte  <= pkt_data;
      cap_idx   <= pkt_idx;
    end
  end

  p_alert_on_error_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && (^{pkt_data, pkt_par}) && !clr) |=> !alert_n);

  p_good_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_n && !clr && pkt_valid && !(^{pkt_data, pkt_par})) |=> alert_n);

  p_invalid_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_n && !pkt_valid) |=> alert_n);

  p_invalid_no_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_valid && !clr) |=> $stable(err_count));

  p_count_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CNT_MAX && !clr) |=> err_count == CNT_MAX);

  p_capture_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !clr) |=> (cap_valid && $stable(cap_byte) && $stable(cap_idx)));

  p_clear_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (alert_n && err_count == '0 && !cap_valid));

endmodule

// File: tb/ca_parity_monitor_bench.sv
module ca_parity_monitor_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pkt_valid, pkt_par, pkt_idx, clr;
  logic [7:0] pkt_data;
  logic       alert_n, cap_valid, cap_idx;
  logic [7:0] err_count, cap_byte;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ca_parity_monitor u_ca_parity_monitor (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .pkt_par(pkt_par), .pkt_idx(pkt_idx), .clr(clr), .alert_n(alert_n),
    .err_count(err_count), .cap_valid(cap_valid), .cap_byte(cap_byte),
    .cap_idx(cap_idx));

  typedef struct packed {
    logic       v;
    logic       idx;
    logic [7:0] data;
    logic       par;
    logic       cl;
    logic       e_alert;
    logic [7:0] e_cnt;
    logic       e_capv;
    logic [7:0] e_capb;
    logic       e_capi;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,8'h00,1'b0,1'b0, 1'b1,8'd0, 1'b0,8'h00,1'b0, 4'd1}, // R1 all zero
    '{1'b1,1'b0,8'h01,1'b1,1'b0, 1'b1,8'd0, 1'b0,8'h00,1'b0, 4'd1}, // R1 parity set
    '{1'b1,1'b1,8'hFF,1'b0,1'b0, 1'b1,8'd0, 1'b0,8'h00,1'b0, 4'd1}, // R1 all ones
    '{1'b0,1'b0,8'h01,1'b0,1'b0, 1'b1,8'd0, 1'b0,8'h00,1'b0, 4'd4}, // R4 bad but not valid
    '{1'b1,1'b0,8'hA5,1'b1,1'b0, 1'b0,8'd1, 1'b1,8'hA5,1'b0, 4'd2}, // R2 bad pkt0
    '{1'b1,1'b1,8'h3C,1'b0,1'b0, 1'b0,8'd1, 1'b1,8'hA5,1'b0, 4'd5}, // R5 good pkt1
    '{1'b0,1'b0,8'h00,1'b0,1'b0, 1'b0,8'd1, 1'b1,8'hA5,1'b0, 4'd3}, // R3
    '{1'b0,1'b0,8'h00,1'b0,1'b0, 1'b0,8'd1, 1'b1,8'hA5,1'b0, 4'd3}, // R3 last low
    '{1'b0,1'b0,8'h00,1'b0,1'b0, 1'b1,8'd1, 1'b1,8'hA5,1'b0, 4'd3}, // R3 released
    '{1'b1,1'b1,8'h80,1'b0,1'b0, 1'b0,8'd2, 1'b1,8'hA5,1'b0, 4'd7}, // R7 keep first
    '{1'b0,1'b0,8'h00,1'b0,1'b0, 1'b0,8'd2, 1'b1,8'hA5,1'b0, 4'd3}, // R3
    '{1'b1,1'b0,8'h07,1'b0,1'b0, 1'b0,8'd3, 1'b1,8'hA5,1'b0, 4'd3}, // R3 restart
    '{1'b0,1'b0,8'h00,1'b0,1'b0, 1'b0,8'd3, 1'b1,8'hA5,1'b0, 4'd3}, // R3
    '{1'b0,1'b0,8'h00,1'b0,1'b0, 1'b0,8'd3, 1'b1,8'hA5,1'b0, 4'd3}, // R3 old window over
    '{1'b0,1'b0,8'h00,1'b0,1'b0, 1'b0,8'd3, 1'b1,8'hA5,1'b0, 4'd3}, // R3
    '{1'b0,1'b0,8'h00,1'b0,1'b0, 1'b1,8'd3, 1'b1,8'hA5,1'b0, 4'd3}, // R3 released
    '{1'b0,1'b0,8'h00,1'b0,1'b1, 1'b1,8'd0, 1'b0,8'h00,1'b0, 4'd8}, // R8 clear
    '{1'b1,1'b1,8'h12,1'b1,1'b0, 1'b0,8'd1, 1'b1,8'h12,1'b1, 4'd7}, // R7 idx 1 recorded
    '{1'b1,1'b0,8'h01,1'b0,1'b1, 1'b1,8'd0, 1'b0,8'h00,1'b0, 4'd8}, // R8 clear beats error
    '{1'b0,1'b0,8'h00,1'b0,1'b0, 1'b1,8'd0, 1'b0,8'h00,1'b0, 4'd8}  // R8 stays idle
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    rst_n = 1'b0; pkt_valid = 1'b0; pkt_data = '0; pkt_par = 1'b0;
    pkt_idx = 1'b0; clr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "alert_n in reset", int'(alert_n), 1);
    chk("R9", "err_count in reset", int'(err_count), 0);
    chk("R9", "cap_valid in reset", int'(cap_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", TBL[i].req, i);
      pkt_valid = TBL[i].v; pkt_idx = TBL[i].idx; pkt_data = TBL[i].data;
      pkt_par = TBL[i].par; clr = TBL[i].cl;
      @(negedge clk);
      chk(tag, "alert_n", int'(alert_n), int'(TBL[i].e_alert));
      chk(tag, "err_count", int'(err_count), int'(TBL[i].e_cnt));
      chk(tag, "cap_valid", int'(cap_valid), int'(TBL[i].e_capv));
      chk(tag, "cap_byte", int'(cap_byte), int'(TBL[i].e_capb));
      chk(tag, "cap_idx", int'(cap_idx), int'(TBL[i].e_capi));
    end
    clr = 1'b0;

    // R6: saturation under a long run of failing packets
    pkt_valid = 1'b1; pkt_data = 8'h01; pkt_par = 1'b0; pkt_idx = 1'b0;
    repeat (260) @(negedge clk);
    pkt_valid = 1'b0;
    chk("R6", "err_count saturated", int'(err_count), 255);
    chk("R6", "alert_n during run", int'(alert_n), 0);
    @(negedge clk);
    chk("R6", "err_count held", int'(err_count), 255);
    repeat (2) @(negedge clk);
    chk("R3", "alert_n fourth low cycle", int'(alert_n), 0);
    @(negedge clk);
    chk("R3", "alert_n released", int'(alert_n), 1);

    // R9: mid-run reset with state loaded
    pkt_valid = 1'b1;
    @(negedge clk);
    chk("R2", "alert_n before reset", int'(alert_n), 0);
    pkt_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R9", "alert_n after reset", int'(alert_n), 1);
    chk("R9", "err_count after reset", int'(err_count), 0);
    chk("R9", "cap_valid after reset", int'(cap_valid), 0);
    chk("R9", "cap_byte after reset", int'(cap_byte), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "alert_n after release", int'(alert_n), 1);

    summary();
  end

endmodule